// File: doc/BRIEF.md
# Wormhole Input Port for a Seven-Port 3D Mesh Router

This block is the receive side of one port of a router in a three-dimensional mesh that uses wormhole switching. Flits arrive over a link with credit-style flow control and are held in a small first-in first-out buffer. When a packet's header flit reaches the front of the buffer, the block decodes the destination coordinates. Using dimension-ordered routing (X first, then Y, then Z), it drives a one-hot request toward one of seven output ports. The block needs no pipeline stage for this decision.

The request stays up until the arbiter answers with a grant. From the next cycle the block streams the whole packet out of its buffer. It uses the second flit, which holds the payload length, to find the final flit. It marks that flit and drops its request once the flit is accepted.

The input side is valid/ready. `in_ready` is the credit: it is high whenever a free buffer slot exists, and a flit is taken only in a cycle where both `in_valid` and `in_ready` are high. The output side is also valid/ready. While `out_valid` is high and `out_ready` is low, `out_flit` and `out_last` hold their values. A flit leaves only in a cycle where both signals are high.

Top module: `wh_input_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `req` is all zeros and `out_valid` is 0.
- R2: The buffer holds 8 flits. `in_ready` falls to 0 once 8 flits are stored and none has left. A flit offered while `in_ready` is 0 is dropped and never appears at the output. `in_ready` returns to 1 after a flit leaves.
- R3: `req` is one-hot or zero. Bit 0 is east, bit 1 west, bit 2 north, bit 3 south, bit 4 top, bit 5 bottom and bit 6 local.
- R4: The header flit holds the target X in bits 3:0, Y in bits 7:4 and Z in bits 11:8. Bits 15:12 are ignored. X is compared first: local X below target X selects east, and above selects west. Only when X matches is Y compared: local Y below target Y selects north, otherwise south. Only when X and Y match is Z compared: local Z below target Z selects top, otherwise bottom. When all three coordinates match, local is selected.
- R5: The request is raised combinationally in the same cycle that a header is at the front of the buffer. It keeps the same value until a grant is seen.
- R6: No flit leaves before the grant. `out_valid` rises in the cycle after the cycle in which `grant` is high with a request up.
- R7: After the grant, the packet leaves in arrival order: header, length flit, then payload flits. A stalled output flit stays stable.
- R8: A packet is 2 plus the length value in flits, and `out_last` is high with the final one. In the cycle after that flit is accepted, `out_valid` is 0. `req` then shows the next buffered packet's route, or zero if no packet is waiting.
- R9: A length value of 0 makes a two-flit packet, with `out_last` on the length flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 4 | This router's X coordinate |
| my_y | input | 4 | This router's Y coordinate |
| my_z | input | 4 | This router's Z coordinate |
| in_valid | input | 1 | Upstream flit is valid |
| in_ready | output | 1 | Credit: a buffer slot is free |
| in_flit | input | 16 | Incoming flit |
| req | output | 7 | One-hot output port request |
| grant | input | 1 | Arbiter grant for the requested port |
| out_valid | output | 1 | Outgoing flit is valid |
| out_ready | input | 1 | Crossbar/downstream can take a flit |
| out_flit | output | 16 | Outgoing flit |
| out_last | output | 1 | Outgoing flit is the final one of its packet |

## Verification
A flit offered in one cycle is stored at that clock edge. Its request is due with no further edge once it is at the front of the buffer. The bench therefore reads `req` just after the negative edge that follows the push. `out_valid` is due one edge after the grant cycle, and the bench samples it at the following negative edge. Each accepted output flit is replaced at the next edge, so the bench compares exactly one flit per negative edge in which `out_ready` is high. The drop of the request and of `out_valid` is due one edge after the final flit is accepted, and is checked at that point.

// File: rtl/wh_pkg.sv
package wh_pkg;
  localparam int N_PORTS = 7;

  typedef enum logic [2:0] {
    PORT_EAST   = 3'd0,
    PORT_WEST   = 3'd1,
    PORT_NORTH  = 3'd2,
    PORT_SOUTH  = 3'd3,
    PORT_TOP    = 3'd4,
    PORT_BOTTOM = 3'd5,
    PORT_LOCAL  = 3'd6
  } port_e;

  typedef enum logic [0:0] {
    ST_HEAD = 1'b0,
    ST_XFER = 1'b1
  } pstate_e;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_LEN = 2'd1,
    PH_PAY = 2'd2
  } phase_e;
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/wh_xyz_route.sv
module wh_xyz_route
  import wh_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0]      here_x,
  input  logic [CW-1:0]      here_y,
  input  logic [CW-1:0]      here_z,
  input  logic [CW-1:0]      dest_x,
  input  logic [CW-1:0]      dest_y,
  input  logic [CW-1:0]      dest_z,
  output logic [N_PORTS-1:0] port_oh
);
  port_e sel;

  always_comb begin
    if (here_x < dest_x)      sel = PORT_EAST;
    else if (here_x > dest_x) sel = PORT_WEST;
    else if (here_y < dest_y) sel = PORT_NORTH;
    else if (here_y > dest_y) sel = PORT_SOUTH;
    else if (here_z < dest_z) sel = PORT_TOP;
    else if (here_z > dest_z) sel = PORT_BOTTOM;
    else                      sel = PORT_LOCAL;
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
    assign port_oh[p] = (sel == port_e'(p));
  end
endmodule

// File: rtl/wh_pkt_ctrl.sv
module wh_pkt_ctrl
  import wh_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       head_flit,
  input  logic               head_valid,
  input  logic [N_PORTS-1:0] route_oh,
  input  logic               grant,
  input  logic               out_ready,
  output logic [N_PORTS-1:0] req,
  output logic               out_valid,
  output logic               out_last,
  output logic               pop
);
  pstate_e            state;
  phase_e             phase;
  logic [W-1:0]       left;
  logic [N_PORTS-1:0] held_route;
  logic               is_last;
  logic               fire;

  always_comb begin
    case (phase)
      PH_LEN:  is_last = (head_flit == '0);
      PH_PAY:  is_last = (left == W'(1));
      default: is_last = 1'b0;
    endcase
  end

  assign out_valid = (state == ST_XFER) && head_valid;
  assign out_last  = out_valid && is_last;
  assign fire      = out_valid && out_ready;
  assign pop       = fire;
  assign req       = (state == ST_XFER) ? held_route
                   : (head_valid ? route_oh : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HEAD;
      phase      <= PH_HDR;
      left       <= '0;
      held_route <= '0;
    end else begin
      case (state)
        ST_HEAD: begin
          if (head_valid && grant) begin
            state      <= ST_XFER;
            held_route <= route_oh;
            phase      <= PH_HDR;
          end
        end
        default: begin
          if (fire) begin
            if (is_last) begin
              state      <= ST_HEAD;
              phase      <= PH_HDR;
              held_route <= '0;
            end else begin
              case (phase)
                PH_HDR: phase <= PH_LEN;
                PH_LEN: begin
                  phase <= PH_PAY;
                  left  <= head_flit;
                end
                default: left <= left - 1'b1;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port
  import wh_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 8,
  parameter int CW     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      my_x,
  input  logic [CW-1:0]      my_y,
  input  logic [CW-1:0]      my_z,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLIT_W-1:0]  in_flit,
  output logic [N_PORTS-1:0] req,
  input  logic               grant,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FLIT_W-1:0]  out_flit,
  output logic               out_last
);
  logic [FLIT_W-1:0]  head;
  logic               empty, full, pop;
  logic [N_PORTS-1:0] route_oh;

  assign in_ready = !full;
  assign out_flit = head;

  wh_flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .wdata (in_flit),
    .pop   (pop),
    .rdata (head),
    .empty (empty),
    .full  (full)
  );

  wh_xyz_route #(.CW(CW)) u_route (
    .here_x  (my_x),
    .here_y  (my_y),
    .here_z  (my_z),
    .dest_x  (head[CW-1:0]),
    .dest_y  (head[2*CW-1:CW]),
    .dest_z  (head[3*CW-1:2*CW]),
    .port_oh (route_oh)
  );

  wh_pkt_ctrl #(.W(FLIT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_flit  (head),
    .head_valid (!empty),
    .route_oh   (route_oh),
    .grant      (grant),
    .out_ready  (out_ready),
    .req        (req),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .pop        (pop)
  );
endmodule

// File: rtl/wh_input_port_chk.sv
module wh_input_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] req,
  input logic       grant,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last
);
  assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req != 7'd0 && !grant && !out_valid) |=> (req == $past(req)));

  assert_send_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (req != 7'd0));

  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));

  assert_last_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> !out_valid);
endmodule

bind wh_input_port wh_input_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .grant     (grant),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last)
);

// File: tb/tb_wh_input_port.sv
module tb_wh_input_port;
  localparam int PERIOD = 10;
  localparam int NV     = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  my_x = 4'd5, my_y = 4'd5, my_z = 4'd5;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_flit = '0;
  logic [6:0]  req;
  logic        grant = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_flit;
  logic        out_last;

  int n_cmp = 0;
  int n_err = 0;

  always #(PERIOD/2) clk = ~clk;

  wh_input_port dut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .my_z(my_z),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .req(req), .grant(grant), .out_valid(out_valid), .out_ready(out_ready),
    .out_flit(out_flit), .out_last(out_last)
  );

  // {my_x, my_y, my_z, dest_x, dest_y, dest_z, expected req}
  localparam logic [30:0] VEC [NV] = '{
    {4'd5, 4'd5, 4'd5,   4'd7,  4'd5, 4'd5,  7'b0000001},
    {4'd5, 4'd5, 4'd5,   4'd2,  4'd9, 4'd1,  7'b0000010},
    {4'd5, 4'd5, 4'd5,   4'd5,  4'd6, 4'd0,  7'b0000100},
    {4'd5, 4'd5, 4'd5,   4'd5,  4'd1, 4'd9,  7'b0001000},
    {4'd5, 4'd5, 4'd5,   4'd5,  4'd5, 4'd12, 7'b0010000},
    {4'd5, 4'd5, 4'd5,   4'd5,  4'd5, 4'd0,  7'b0100000},
    {4'd5, 4'd5, 4'd5,   4'd5,  4'd5, 4'd5,  7'b1000000},
    {4'd0, 4'd15, 4'd3,  4'd15, 4'd0, 4'd0,  7'b0000001},
    {4'd15, 4'd0, 4'd7,  4'd15, 4'd0, 4'd7,  7'b1000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] f);
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = f;
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic give_grant();
    grant = 1'b1;
    @(posedge clk);
    #1 grant = 1'b0;
  endtask

  task automatic take(input string tag, input logic [15:0] f, input logic last);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " flit"}, 32'(out_flit), 32'(f));
    chk({tag, " last"}, 32'(out_last), 32'(last));
  endtask

  task automatic after_pkt(input string tag, input logic [6:0] exp_req);
    @(negedge clk);
    #1;
    chk({tag, " out_valid low"}, 32'(out_valid), 32'd0);
    chk({tag, " req"}, 32'(req), 32'(exp_req));
  endtask

  initial begin
    #(PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
    chk("R1 req in reset", 32'(req), 32'd0);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 req after reset", 32'(req), 32'd0);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);

    // Routing table walk: R3, R4, R5, R6, R7, R8
    for (int i = 0; i < NV; i++) begin
      logic [15:0] hdr;
      {my_x, my_y, my_z} = VEC[i][30:19];
      hdr = {4'hA, VEC[i][10:7], VEC[i][14:11], VEC[i][18:15]};
      send(hdr);
      send(16'd1);
      send(16'hC000 + 16'(i));
      stop_in();
      chk("R4 route select", 32'(req), 32'(VEC[i][6:0]));
      chk("R6 no flit before grant", 32'(out_valid), 32'd0);
      @(negedge clk);
      #1;
      chk("R5 request held", 32'(req), 32'(VEC[i][6:0]));
      give_grant();
      take("R7 header", hdr, 1'b0);
      take("R7 length", 16'd1, 1'b0);
      take("R8 payload", 16'hC000 + 16'(i), 1'b1);
      after_pkt("R8 release", 7'd0);
    end

    // R2: fill buffer with an 8-flit packet, offer a 9th that must be dropped
    my_x = 4'd5; my_y = 4'd5; my_z = 4'd5;
    send(16'h0555);
    send(16'd6);
    for (int k = 0; k < 6; k++) send(16'hB000 + 16'(k));
    @(negedge clk);
    in_flit = 16'hDEAD;
    #1;
    chk("R2 credit withdrawn when full", 32'(in_ready), 32'd0);
    stop_in();
    chk("R5 local request", 32'(req), 32'b1000000);
    give_grant();
    begin
      int got = 0;
      int cyc = 0;
      logic [15:0] stalled = '0;
      logic        was_stalled = 1'b0;
      while (got < 8 && cyc < 100) begin
        logic [15:0] ef;
        @(negedge clk);
        out_ready = cyc[0];
        #1;
        ef = (got == 0) ? 16'h0555 : (got == 1) ? 16'd6 : 16'hB000 + 16'(got - 2);
        if (was_stalled) chk("R7 stalled flit stable", 32'(out_flit), 32'(stalled));
        chk("R7 drain flit", 32'(out_flit), 32'(ef));
        chk("R8 drain last", 32'(out_last), 32'(got == 7));
        was_stalled = !out_ready;
        stalled = out_flit;
        if (out_valid && out_ready) got++;
        cyc++;
      end
      chk("R7 all flits drained", 32'(got), 32'd8);
    end
    #1;
    chk("R2 credit returns", 32'(in_ready), 32'd1);
    out_ready = 1'b1;
    after_pkt("R2 dropped flit absent", 7'd0);

    // R9: zero-length packet is two flits
    send(16'h0555);
    send(16'd0);
    stop_in();
    give_grant();
    take("R9 header", 16'h0555, 1'b0);
    take("R9 length is last", 16'd0, 1'b1);
    after_pkt("R9 release", 7'd0);

    // R8: back-to-back packets, second request raised right after first ends
    send(16'h0557);
    send(16'd1);
    send(16'h1111);
    send(16'h0955);
    send(16'd1);
    send(16'h2222);
    stop_in();
    chk("R4 first of pair east", 32'(req), 32'b0000001);
    give_grant();
    take("R7 pair A header", 16'h0557, 1'b0);
    take("R7 pair A length", 16'd1, 1'b0);
    take("R8 pair A payload", 16'h1111, 1'b1);
    after_pkt("R8 next request top", 7'b0010000);
    give_grant();
    take("R7 pair B header", 16'h0955, 1'b0);
    take("R7 pair B length", 16'd1, 1'b0);
    take("R8 pair B payload", 16'h2222, 1'b1);
    after_pkt("R8 pair B release", 7'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule